// File: doc/BRIEF.md
# Flag Offset Programmer

This block holds the four offset values that a pair of FIFOs uses to raise their almost-empty and almost-full flags. There is one empty-side offset and one full-side offset for each FIFO: `y1_o` and `x1_o` for the first FIFO, `y2_o` and `x2_o` for the second. Each offset is `W = log2(DEPTH)` bits wide. The logic that compares the offsets against the FIFO fill level is outside this block.

The programming method is decided once, on the first clock edge after the active-low master reset is released. The mode pin and the two dual-purpose select pins are sampled on that edge. The block then works in one of three methods:
- Preset: it loads one of three fixed offsets into all four registers.
- Parallel: it accepts four strobed words from the data bus, one word per register.
- Serial: it shifts the offsets in one bit per clock. One select pin acts as an active-low enable and the other carries the data bit.

When the chosen method has filled all four registers, a sticky done flag rises. After that the registers stay frozen until the next master reset.

Top module: `flag_offset_prog`

## Requirements
- R1: The method and the preset choice are captured from `spm_i` and `fsel_i` on the first rising clock edge after `rst_ni` goes high. Later changes on those pins do not alter the method.
- R2: The method is decoded as follows. `spm_i`=0 selects serial. With `spm_i`=1, `fsel_i`=00 selects parallel, 01 selects preset 8, 10 selects preset 16 and 11 selects preset 64.
- R3: In preset mode, all four registers take the preset value on the second rising edge after reset release. `done_o` rises on that same edge and is low before it.
- R4: In serial mode, each rising edge with `fsel_i[1]`=0 shifts `fsel_i[0]` into the chain. Edges with `fsel_i[1]`=1 leave all registers unchanged.
- R5: The serial chain runs Y1, X1, Y2, X2, each register MSB first. A newly shifted bit enters at the LSB of X2, so after a full program the first bit sits in the MSB of Y1 and the last bit in the LSB of X2.
- R6: `done_o` rises on the edge that takes serial bit number 4·W (32 bits when DEPTH=256). Further serial bits are ignored and `done_o` stays high until master reset.
- R7: In parallel mode, each rising edge with `ld_i`=1 writes `data_i[W-1:0]` into the next register in the order Y1, X1, Y2, X2. `done_o` rises with the fourth write, and later strobes are ignored.
- R8: The register width W equals log2(DEPTH), which is 8 bits for DEPTH=256.
- R9: While `rst_ni` is low, all four offsets read 0 and `done_o` reads 0.
- R10: Some inputs belong to a method that is not active and have no effect:
  - `ld_i` has no effect in serial or preset mode.
  - The serial enable `fsel_i[1]` has no effect in parallel or preset mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port-side clock, rising edge active |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| spm_i | input | 1 | Method pin: 0 selects serial, 1 selects parallel or preset |
| fsel_i | input | 2 | Preset/parallel select. In serial mode, bit 1 is the active-low enable and bit 0 is the data bit |
| ld_i | input | 1 | Parallel write strobe |
| data_i | input | DATA_W | Parallel data bus; only the low W bits are used |
| y1_o | output | W | FIFO 1 empty-side offset |
| x1_o | output | W | FIFO 1 full-side offset |
| y2_o | output | W | FIFO 2 empty-side offset |
| x2_o | output | W | FIFO 2 full-side offset |
| done_o | output | 1 | Programming complete (sticky until master reset) |

## Verification
The assertions assume three things about the inputs:
- `spm_i` and `fsel_i` are stable around the edge that captures the method.
- In serial mode, the enable and data pins change only away from the clock edge.
- `DEPTH` is at least 128, so that the 64 preset fits in the register.

The stimulus respects these assumptions by driving every pin on the falling clock edge and by holding the method pins through the capture edge. It changes the pins afterwards only on purpose, to show that the captured method persists. Each programming run begins with a fresh master reset, so the sticky done flag and the method latch never carry over from one run to the next.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;

  typedef enum logic [1:0] {
    OM_IDLE     = 2'd0,
    OM_SERIAL   = 2'd1,
    OM_PARALLEL = 2'd2,
    OM_PRESET   = 2'd3
  } ofs_mode_e;

  localparam int unsigned NUM_SLOTS = 4;

  function automatic ofs_mode_e decode_mode(logic spm, logic [1:0] sel);
    if (!spm) return OM_SERIAL;
    if (sel == 2'b00) return OM_PARALLEL;
    return OM_PRESET;
  endfunction

  function automatic int unsigned preset_of(logic [1:0] sel);
    case (sel)
      2'b01:   return 8;
      2'b10:   return 16;
      2'b11:   return 64;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/ofs_mode_latch.sv
module ofs_mode_latch
  import ofs_prog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       spm_i,
  input  logic [1:0] fsel_i,
  output ofs_mode_e  mode_o,
  output logic [1:0] psel_o
);
  ofs_mode_e  mode_q;
  logic [1:0] psel_q;

  // captures once: first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= OM_IDLE;
      psel_q <= 2'b00;
    end else if (mode_q == OM_IDLE) begin
      mode_q <= decode_mode(spm_i, fsel_i);
      psel_q <= fsel_i;
    end
  end

  assign mode_o = mode_q;
  assign psel_o = psel_q;
endmodule

// File: rtl/ofs_step_counter.sv
module ofs_step_counter #(
  parameter int unsigned LIMIT = 32,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  output logic [CW-1:0] cnt_o,
  output logic          full_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (step_i && cnt_q != CW'(LIMIT))  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/ofs_offset_store.sv
module ofs_offset_store #(
  parameter int unsigned W     = 8,
  parameter int unsigned SLOTS = 4,
  localparam int unsigned SW   = $clog2(SLOTS),
  localparam int unsigned CH   = SLOTS * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fill_en_i,
  input  logic [W-1:0]  fill_val_i,
  input  logic          shift_en_i,
  input  logic          shift_bit_i,
  input  logic          wr_en_i,
  input  logic [SW-1:0] wr_slot_i,
  input  logic [W-1:0]  wr_data_i,
  output logic [CH-1:0] chain_o
);
  logic [W-1:0] slot_q [SLOTS];
  logic [SLOTS-1:0] in_bit;

  // slot 0 is the head of the chain (Y1); serial data enters the tail slot
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    if (k == SLOTS - 1) begin : g_tail
      assign in_bit[k] = shift_bit_i;
    end else begin : g_link
      assign in_bit[k] = slot_q[k+1][W-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 slot_q[k] <= '0;
      else if (fill_en_i)                          slot_q[k] <= fill_val_i;
      else if (shift_en_i)                         slot_q[k] <= {slot_q[k][W-2:0], in_bit[k]};
      else if (wr_en_i && wr_slot_i == SW'(k))     slot_q[k] <= wr_data_i;
    end

    assign chain_o[(SLOTS-k)*W-1 -: W] = slot_q[k];
  end
endmodule

// File: rtl/flag_offset_prog.sv
module flag_offset_prog
  import ofs_prog_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 36,
  localparam int unsigned W     = $clog2(DEPTH),
  localparam int unsigned SLOTS = NUM_SLOTS,
  localparam int unsigned SW    = $clog2(SLOTS),
  localparam int unsigned CH    = SLOTS * W,
  localparam int unsigned SCW   = $clog2(CH + 1),
  localparam int unsigned PCW   = $clog2(SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spm_i,
  input  logic [1:0]        fsel_i,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [W-1:0]      y1_o,
  output logic [W-1:0]      x1_o,
  output logic [W-1:0]      y2_o,
  output logic [W-1:0]      x2_o,
  output logic              done_o
);
  ofs_mode_e      mode_q;
  logic [1:0]     psel_q;
  logic           ser_full, par_full, preset_done_q;
  logic           ser_step, par_step, fill_en;
  logic [SCW-1:0] ser_cnt;
  logic [PCW-1:0] par_cnt;
  logic [CH-1:0]  chain;

  ofs_mode_latch i_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .spm_i  (spm_i),
    .fsel_i (fsel_i),
    .mode_o (mode_q),
    .psel_o (psel_q)
  );

  assign ser_step = (mode_q == OM_SERIAL)   && !fsel_i[1] && !ser_full;
  assign par_step = (mode_q == OM_PARALLEL) && ld_i       && !par_full;
  assign fill_en  = (mode_q == OM_PRESET)   && !preset_done_q;

  ofs_step_counter #(.LIMIT(CH)) i_ser_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (ser_step),
    .cnt_o  (ser_cnt),
    .full_o (ser_full)
  );

  ofs_step_counter #(.LIMIT(SLOTS)) i_par_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (par_step),
    .cnt_o  (par_cnt),
    .full_o (par_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      preset_done_q <= 1'b0;
    else if (fill_en) preset_done_q <= 1'b1;
  end

  ofs_offset_store #(.W(W), .SLOTS(SLOTS)) i_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fill_en_i   (fill_en),
    .fill_val_i  (W'(preset_of(psel_q))),
    .shift_en_i  (ser_step),
    .shift_bit_i (fsel_i[0]),
    .wr_en_i     (par_step),
    .wr_slot_i   (par_cnt[SW-1:0]),
    .wr_data_i   (data_i[W-1:0]),
    .chain_o     (chain)
  );

  assign y1_o   = chain[4*W-1 -: W];
  assign x1_o   = chain[3*W-1 -: W];
  assign y2_o   = chain[2*W-1 -: W];
  assign x2_o   = chain[W-1:0];
  assign done_o = ser_full | par_full | preset_done_q;
endmodule

// File: rtl/ofs_prog_chk.sv
module ofs_prog_chk
  import ofs_prog_pkg::*;
#(
  parameter int unsigned W = 8,
  localparam int unsigned CH = 4 * W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    mode_i,
  input logic [1:0]    fsel_i,
  input logic          ld_i,
  input logic [CH-1:0] chain_i,
  input logic          done_i
);
  logic ser_go;
  assign ser_go = (mode_i == OM_SERIAL) && !done_i && !fsel_i[1];

  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != OM_IDLE) |=> $stable(mode_i));                                        // R1
  AST_PRESET_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OM_PRESET && done_i) |-> $countones(chain_i[W-1:0]) == 1);            // R3
  AST_SER_INSERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_go |=> chain_i[0] == $past(fsel_i[0]));                                      // R4
  AST_SER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OM_SERIAL && fsel_i[1]) |=> $stable(chain_i));                        // R4
  AST_SER_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_go |=> chain_i[CH-1:1] == $past(chain_i[CH-2:0]));                           // R5
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> done_i);                                                              // R6
  AST_FROZEN_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> $stable(chain_i));                                                    // R7
  AST_PAR_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OM_PARALLEL && !ld_i) |=> $stable(chain_i));                          // R10
endmodule

bind flag_offset_prog ofs_prog_chk #(.W(W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mode_i  (mode_q),
  .fsel_i  (fsel_i),
  .ld_i    (ld_i),
  .chain_i (chain),
  .done_i  (done_o)
);

// File: tb/test_flag_offset_prog.sv
module test_flag_offset_prog;
  localparam int DEPTH  = 256;
  localparam int DATA_W = 36;
  localparam int W      = 8;

  typedef struct packed {
    logic        spm;
    logic [1:0]  sel;
    logic [31:0] stim;
    logic [31:0] expv;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b1, 2'b01, 32'h0000_0000, 32'h0808_0808},
    '{1'b1, 2'b10, 32'h0000_0000, 32'h1010_1010},
    '{1'b1, 2'b11, 32'h0000_0000, 32'h4040_4040},
    '{1'b0, 2'b10, 32'hA53C_0FF1, 32'hA53C_0FF1},
    '{1'b0, 2'b10, 32'h8000_0001, 32'h8000_0001},
    '{1'b1, 2'b00, 32'h1234_5678, 32'h1234_5678},
    '{1'b1, 2'b00, 32'hFF00_8001, 32'hFF00_8001}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spm = 1'b1;
  logic [1:0] fsel = 2'b10;
  logic ld = 1'b0;
  logic [DATA_W-1:0] data = '0;
  logic [W-1:0] y1, x1, y2, x2;
  logic done;
  logic [31:0] regs;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  flag_offset_prog #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_flag_offset_prog (
    .clk_i(clk), .rst_ni(rst_n), .spm_i(spm), .fsel_i(fsel), .ld_i(ld),
    .data_i(data), .y1_o(y1), .x1_o(x1), .y2_o(y2), .x2_o(x2), .done_o(done)
  );

  assign regs = {y1, x1, y2, x2};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start(logic s, logic [1:0] sel);
    rst_n = 1'b0; spm = s; fsel = sel; ld = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    if (!s) fsel = 2'b10;
  endtask

  task automatic shift_bit(logic b);
    fsel = {1'b0, b};
    @(negedge clk);
    fsel = 2'b10;
  endtask

  task automatic shift_word(logic [31:0] w, int nbits);
    for (int i = 31; i > 31 - nbits; i--) shift_bit(w[i]);
  endtask

  task automatic par_load(logic [W-1:0] b);
    data = {{(DATA_W-W){1'b1}}, b};
    ld = 1'b1;
    @(negedge clk);
    ld = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    @(negedge clk);
    check("R9 reset offsets", regs, 32'h0);
    check("R9 reset done", {31'b0, done}, 32'h0);
    check("R8 width", $bits(y1), W);

    for (int v = 0; v < 7; v++) begin
      start(VECS[v].spm, VECS[v].sel);
      if (VECS[v].spm && VECS[v].sel != 2'b00) begin
        check("R3 done before fill", {31'b0, done}, 32'h0);
        @(negedge clk);
        check("R2 R3 preset value", regs, VECS[v].expv);
        check("R3 preset done", {31'b0, done}, 32'h1);
      end else if (!VECS[v].spm) begin
        shift_word(VECS[v].stim, 32);
        check("R5 serial order", regs, VECS[v].expv);
        check("R6 serial done", {31'b0, done}, 32'h1);
      end else begin
        for (int i = 3; i >= 0; i--) par_load(VECS[v].stim[i*8 +: 8]);
        check("R7 parallel order", regs, VECS[v].expv);
        check("R7 parallel done", {31'b0, done}, 32'h1);
      end
    end

    // R6: exact bit count, then extra bits ignored
    start(1'b0, 2'b10);
    shift_word(32'h5A5A_C3C3, 31);
    check("R6 done low at 31 bits", {31'b0, done}, 32'h0);
    shift_bit(1'b1);
    check("R6 done at 32 bits", {31'b0, done}, 32'h1);
    check("R6 value", regs, 32'h5A5A_C3C3);
    for (int i = 0; i < 8; i++) shift_bit(1'b0);
    check("R6 extra bits ignored", regs, 32'h5A5A_C3C3);

    // R4/R5/R10: partial chain, idle enable, stray strobe
    start(1'b0, 2'b10);
    shift_word(32'hC300_0000, 8);
    check("R5 entry at X2 LSB", regs, 32'h0000_00C3);
    repeat (3) @(negedge clk);
    check("R4 enable high holds", regs, 32'h0000_00C3);
    par_load(8'h77);
    check("R10 strobe ignored in serial", regs, 32'h0000_00C3);
    check("R10 no done from strobe", {31'b0, done}, 32'h0);

    // R1/R10: parallel captured, pins changed afterwards
    start(1'b1, 2'b00);
    spm = 1'b0; fsel = 2'b01;
    repeat (3) @(negedge clk);
    check("R10 serial enable ignored in parallel", regs, 32'h0);
    check("R1 method kept, no done", {31'b0, done}, 32'h0);
    par_load(8'hDE); par_load(8'hAD); par_load(8'hBE); par_load(8'hEF);
    check("R1 parallel still active", regs, 32'hDEAD_BEEF);
    par_load(8'h55);
    check("R7 fifth strobe ignored", regs, 32'hDEAD_BEEF);

    // R10: strobe in preset mode
    start(1'b1, 2'b10);
    @(negedge clk);
    par_load(8'h01);
    check("R10 strobe ignored in preset", regs, 32'h1010_1010);

    summary();
  end
endmodule